// File: doc/BRIEF.md
# Receive Data-Ready and Time-Out Interrupt Generator

This block decides when a UART receiver should interrupt the host about waiting data. It watches the fill count of an external receive FIFO. In per-character mode it raises a data-ready interrupt as soon as any byte is waiting. In trigger mode it holds the interrupt off until the fill reaches a selectable threshold. The FIFO itself lives outside the block; only its count is an input.

A time-out keeps a few bytes from sitting unread below the threshold. The block counts 16x baud ticks while the FIFO holds data. Every received character and every host read restarts the count. When no restart has come for four character lengths plus twelve bit times, a time-out interrupt is raised. The length of that window follows the configured word length: 32 bit times for 5-bit characters, up to 44 bit times for 8-bit characters. That is roughly 3.7 to 4.6 character times. A single enable input gates both interrupts.

Top module: `rx_alert`

## Requirements
- R1: With `trigMode` = 0 and `rxIrqEn` = 1, `dataIrq` is high in the cycle after any cycle in which `fillCount` is non-zero, and low in the cycle after `fillCount` is zero.
- R2: With `trigMode` = 1, the threshold is chosen by `trigSel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `dataIrq` is high in the cycle after `fillCount` is at or above the threshold.
- R3: In trigger mode, `dataIrq` goes low in the cycle after `fillCount` falls below the selected threshold.
- R4: The time-out window is 16 × (4 × (w + 5) + 12) ticks, where `wordLen` = w, with 00 meaning 5 data bits and 11 meaning 8. That gives 512, 576, 640 and 704 ticks. `timeoutIrq` rises right after the edge that takes the tick completing the window, counted from the last restart with the FIFO non-empty.
- R5: Once raised, `timeoutIrq` stays high, even when further characters arrive, until a cycle with `hostRead` high. It is low after that edge.
- R6: A `charIn` or `hostRead` pulse resets the tick count to zero. A full new window is then needed before a time-out.
- R7: While `fillCount` is zero, the tick count is held at zero and no time-out is raised, however many ticks pass.
- R8: When a `charIn` or `hostRead` pulse falls in the same cycle as the tick that would complete the window, the restart wins. No time-out is raised and a fresh window starts.
- R9: With `rxIrqEn` = 0, `dataIrq` is low from the next cycle and `timeoutIrq` is low. A time-out that expires while disabled appears on `timeoutIrq` as soon as `rxIrqEn` returns to 1.
- R10: After reset, both `dataIrq` and `timeoutIrq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16 times the baud rate |
| charIn | input | 1 | One-cycle pulse: a character entered the FIFO |
| hostRead | input | 1 | One-cycle pulse: the host read a byte |
| fillCount | input | 5 | Current receive FIFO fill count (0 to 16) |
| trigMode | input | 1 | 0 = interrupt per character, 1 = interrupt at threshold |
| trigSel | input | 2 | Threshold select: 00=1, 01=4, 10=8, 11=14 |
| wordLen | input | 2 | Data bits per character minus 5 |
| rxIrqEn | input | 1 | Receive interrupt enable |
| dataIrq | output | 1 | Data-ready interrupt, registered |
| timeoutIrq | output | 1 | Receive time-out interrupt |

## Verification
The two events that can share a cycle are the tick that completes the time-out window and a restart pulse. The restart is either a host read or a new character. The bench drives exactly one tick short of the window, then applies the completing tick together with `hostRead`, and in a separate run together with `charIn`. It judges the result in two ways. First, `timeoutIrq` must stay low after that edge. Second, it must rise only after a further complete window, which shows the count really restarted rather than froze.

// File: rtl/rx_alert_pkg.sv
package rx_alert_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic expire;
    logic levelMet;
    logic empty;
  } dpStatus_t;

endpackage

// File: rtl/rx_alert_dp.sv
module rx_alert_dp
  import rx_alert_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int MIN_BITS      = 5,
  parameter int CHAR_COUNT    = 4,
  parameter int GUARD_BITS    = 12,
  parameter int LVL0          = 1,
  parameter int LVL1          = 4,
  parameter int LVL2          = 8,
  parameter int LVL3          = 14,
  localparam int FILL_W       = $clog2(DEPTH + 1),
  localparam int MAX_TICKS    = TICKS_PER_BIT * (CHAR_COUNT * (MIN_BITS + 3) + GUARD_BITS),
  localparam int CNT_W        = $clog2(MAX_TICKS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic [FILL_W-1:0] fillCount,
  input  logic              trigMode,
  input  logic [1:0]        trigSel,
  input  logic [1:0]        wordLen,
  input  ctlStrobe_t        ctl,
  output dpStatus_t         status
);

  localparam int NUM_LVL = 4;
  localparam int LVL_TAB [NUM_LVL] = '{LVL0, LVL1, LVL2, LVL3};

  // one comparator per selectable threshold
  logic [NUM_LVL-1:0] levelHit;
  for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
    assign levelHit[i] = (fillCount >= FILL_W'(LVL_TAB[i]));
  end

  logic anyData;
  assign anyData = (fillCount != '0);

  always_comb begin
    status.empty    = !anyData;
    status.levelMet = trigMode ? levelHit[trigSel] : anyData;
  end

  // window length in ticks for the configured word length
  logic [CNT_W-1:0] limit;
  always_comb begin
    int bits;
    bits  = CHAR_COUNT * (MIN_BITS + int'(wordLen)) + GUARD_BITS;
    limit = CNT_W'(bits * TICKS_PER_BIT);
  end

  logic [CNT_W-1:0] tickCnt;
  logic             atEnd;
  assign atEnd = (tickCnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN)                tickCnt <= '0;
    else if (ctl.restart)     tickCnt <= '0;
    else if (tick16 && !atEnd) tickCnt <= tickCnt + 1'b1;
  end

  assign status.expire = tick16 && !ctl.restart && (tickCnt == limit - 1'b1);

endmodule

// File: rtl/rx_alert_ctl.sv
module rx_alert_ctl
  import rx_alert_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       charIn,
  input  logic       hostRead,
  input  logic       rxIrqEn,
  input  dpStatus_t  status,
  output ctlStrobe_t ctl,
  output logic       dataIrq,
  output logic       timeoutIrq
);

  logic toFlag;

  assign ctl.restart = charIn || hostRead || status.empty;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toFlag  <= 1'b0;
      dataIrq <= 1'b0;
    end else begin
      dataIrq <= rxIrqEn && status.levelMet;
      if (hostRead)           toFlag <= 1'b0;
      else if (status.expire) toFlag <= 1'b1;
    end
  end

  assign timeoutIrq = toFlag && rxIrqEn;

endmodule

// File: rtl/rx_alert.sv
module rx_alert
  import rx_alert_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  localparam int FILL_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              charIn,
  input  logic              hostRead,
  input  logic [FILL_W-1:0] fillCount,
  input  logic              trigMode,
  input  logic [1:0]        trigSel,
  input  logic [1:0]        wordLen,
  input  logic              rxIrqEn,
  output logic              dataIrq,
  output logic              timeoutIrq
);

  ctlStrobe_t ctl;
  dpStatus_t  status;

  rx_alert_dp #(
    .DEPTH        (DEPTH),
    .TICKS_PER_BIT(TICKS_PER_BIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .fillCount(fillCount),
    .trigMode (trigMode),
    .trigSel  (trigSel),
    .wordLen  (wordLen),
    .ctl      (ctl),
    .status   (status)
  );

  rx_alert_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .charIn    (charIn),
    .hostRead  (hostRead),
    .rxIrqEn   (rxIrqEn),
    .status    (status),
    .ctl       (ctl),
    .dataIrq   (dataIrq),
    .timeoutIrq(timeoutIrq)
  );

endmodule

// File: rtl/rx_alert_chk.sv
module rx_alert_chk #(
  parameter int FILL_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              charIn,
  input logic              hostRead,
  input logic [FILL_W-1:0] fillCount,
  input logic              trigMode,
  input logic              rxIrqEn,
  input logic              dataIrq,
  input logic              timeoutIrq
);

  // R1
  per_char_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!trigMode && rxIrqEn && fillCount != '0) |=> dataIrq);

  // R3
  empty_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillCount == '0) |=> !dataIrq);

  // R5
  read_clears_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostRead |=> !timeoutIrq);

  // R7
  timeout_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(timeoutIrq) && $past(rxIrqEn)) |-> ($past(fillCount) != '0));

  // R8
  restart_blocks_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((hostRead || charIn) && rxIrqEn) |=> !$rose(timeoutIrq));

  // R9
  disabled_no_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rxIrqEn |=> !dataIrq);

endmodule

bind rx_alert rx_alert_chk #(.FILL_W(FILL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .charIn    (charIn),
  .hostRead  (hostRead),
  .fillCount (fillCount),
  .trigMode  (trigMode),
  .rxIrqEn   (rxIrqEn),
  .dataIrq   (dataIrq),
  .timeoutIrq(timeoutIrq)
);

// File: tb/test_rx_alert.sv
module test_rx_alert;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       charIn = 1'b0;
  logic       hostRead = 1'b0;
  logic [4:0] fillCount = '0;
  logic       trigMode = 1'b0;
  logic [1:0] trigSel = '0;
  logic [1:0] wordLen = '0;
  logic       rxIrqEn = 1'b0;
  logic       dataIrq;
  logic       timeoutIrq;

  always #5 clk = ~clk;

  rx_alert i_rx_alert (
    .clk(clk), .rstN(rstN), .tick16(tick16), .charIn(charIn),
    .hostRead(hostRead), .fillCount(fillCount), .trigMode(trigMode),
    .trigSel(trigSel), .wordLen(wordLen), .rxIrqEn(rxIrqEn),
    .dataIrq(dataIrq), .timeoutIrq(timeoutIrq)
  );

  // shadow settings applied at each driven step
  int         fillV = 0;
  logic       modeV = 1'b0;
  logic [1:0] selV = '0;
  logic [1:0] wlV = '0;
  logic       enV = 1'b1;

  int compared = 0;
  int mismatched = 0;
  logic [1:0] expQ[$];
  string      tagQ[$];
  bit         done = 1'b0;

  function automatic int lvlOf(logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int windowOf(logic [1:0] w);
    return 16 * (4 * (int'(w) + 5) + 12);
  endfunction

  function automatic logic expReady();
    int thr;
    thr = modeV ? lvlOf(selV) : 1;
    return enV && (fillV >= thr);
  endfunction

  // driver: apply one cycle of stimulus and queue the expected outputs
  task automatic step(input logic c, input logic r, input logic t,
                      input logic expT, input string tag);
    @(negedge clk);
    charIn    = c;
    hostRead  = r;
    tick16    = t;
    fillCount = 5'(fillV);
    trigMode  = modeV;
    trigSel   = selV;
    wordLen   = wlV;
    rxIrqEn   = enV;
    expQ.push_back({expReady(), expT});
    tagQ.push_back(tag);
  endtask

  task automatic ticks(input int n, input logic expT, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b1, expT, tag);
  endtask

  // monitor: compare after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        logic [1:0] e;
        string      tg;
        e  = expQ.pop_front();
        tg = tagQ.pop_front();
        compared++;
        if ({dataIrq, timeoutIrq} !== e) begin
          mismatched++;
          $display("FAIL %s: dataIrq/timeoutIrq actual %b%b expected %b%b",
                   tg, dataIrq, timeoutIrq, e[1], e[0]);
        end
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R10 reset state
    step(0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R10");

    // R1 per-character mode
    modeV = 1'b0; enV = 1'b1;
    fillV = 0; step(0, 0, 0, 0, "R1");
    fillV = 1; step(1, 0, 0, 0, "R1");
    fillV = 7; step(1, 0, 0, 0, "R1");
    fillV = 0; step(0, 1, 0, 0, "R1");

    // R2 / R3 threshold levels
    modeV = 1'b1;
    for (int s = 0; s < 4; s++) begin
      selV  = 2'(s);
      fillV = lvlOf(2'(s)) - 1; step(0, 0, 0, 0, "R2");
      fillV = lvlOf(2'(s));     step(1, 0, 0, 0, "R2");
      fillV = lvlOf(2'(s)) + 1; step(1, 0, 0, 0, "R2");
      fillV = lvlOf(2'(s)) - 1; step(0, 1, 0, 0, "R3");
    end
    fillV = 8; selV = 2'd3; step(0, 0, 0, 0, "R3");

    // R4 window per word length (threshold 14, two bytes waiting)
    selV = 2'd3; fillV = 2;
    for (int w = 0; w < 4; w++) begin
      wlV = 2'(w);
      step(1, 0, 0, 0, "R4");
      ticks(windowOf(2'(w)) - 1, 0, "R4");
      ticks(1, 1, "R4");
      step(0, 0, 0, 1, "R5");
      step(1, 0, 0, 1, "R5");
      step(0, 1, 0, 0, "R5");
    end

    // R6 mid-window restart by a new character
    wlV = 2'd0;
    step(1, 0, 0, 0, "R6");
    ticks(300, 0, "R6");
    step(1, 0, 0, 0, "R6");
    ticks(511, 0, "R6");
    ticks(1, 1, "R6");
    step(0, 1, 0, 0, "R6");

    // R7 empty FIFO holds the count
    fillV = 0;
    step(0, 0, 0, 0, "R7");
    ticks(700, 0, "R7");
    fillV = 2;
    ticks(511, 0, "R7");
    ticks(1, 1, "R7");
    step(0, 1, 0, 0, "R7");

    // R8 read collides with the expiring tick
    step(1, 0, 0, 0, "R8");
    ticks(511, 0, "R8");
    step(0, 1, 1, 0, "R8");
    ticks(511, 0, "R8");
    ticks(1, 1, "R8");
    step(0, 1, 0, 0, "R8");
    // R8 new character collides with the expiring tick
    ticks(511, 0, "R8");
    step(1, 0, 1, 0, "R8");
    ticks(511, 0, "R8");
    ticks(1, 1, "R8");
    step(0, 1, 0, 0, "R8");

    // R9 enable masks both, pending time-out shows on re-enable
    selV = 2'd0; fillV = 14; enV = 1'b0;
    step(1, 0, 0, 0, "R9");
    ticks(512, 0, "R9");
    step(0, 0, 0, 0, "R9");
    enV = 1'b1;
    step(0, 0, 0, 1, "R9");
    step(0, 1, 0, 0, "R9");
    step(0, 0, 0, 0, "R9");

    @(negedge clk);
    charIn = 0; hostRead = 0; tick16 = 0;
    while (expQ.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule